// File: doc/BRIEF.md
# Vertical-Blanking Video Identification Encoder

This block puts a 20-bit identification packet on one blanking line of each field. A host writes 14 payload bits through two byte-wide write strobes. The block adds a 6-bit CRC, shifts the 20 bits out at a fixed bit period, and drives a level code with a valid flag. A downstream mixer uses that pair to override the video sample on the chosen line.

Line, field and pixel position arrive as inputs from the video timing generator. A one-cycle vertical-sync pulse moves the host's staged payload into the active copy. Packets are taken only from the active copy, so a host write never tears a packet.

The bit period is an integer clock count plus a fraction. A small accumulator stretches selected bits by one clock, so the packet length tracks the nominal time with no drift.

Top module: `vid_id_enc`

## Requirements
- R1: After reset, id_valid is 0, id_level equals LO_CODE and the active payload is all zeros. A packet sent before any vertical sync therefore carries 14 zero payload bits.
- R2: The packet is sent first-bit-first as payload bits p1..p14 followed by the CRC. A write with wr_sel=0 sets p1..p6 from wr_data[0]..wr_data[5]; wr_data[7:6] are reserved and ignored. A write with wr_sel=1 sets p7..p14 from wr_data[0]..wr_data[7].
- R3: The CRC uses generator x^6+x+1 and a register preset to all ones. It is clocked over p1..p14 in send order, and its six bits go out most significant bit first.
- R4: A packet starts only on field 0 line LINE_F0, or on field 1 line LINE_F1_525 (sys625=0) or line LINE_F1_625 (sys625=1). Any other line or field pairing produces no packet.
- R5: id_valid rises on the clock after the one in which pix_pos equals START_PIX on a qualifying line. It stays high for exactly 20*BIT_INT + floor(20*FRAC_NUM/FRAC_DEN) clocks. Each bit is BIT_INT clocks long, plus one extra clock whenever a FRAC_NUM-per-bit accumulator, cleared at packet start, reaches FRAC_DEN; FRAC_DEN is then subtracted.
- R6: While id_valid is high, id_level is HI_CODE for a 1 bit and LO_CODE for a 0 bit. While id_valid is low, id_level is LO_CODE.
- R7: Written payload bits reach packets only after the next vsync pulse. Packets sent between a write and that pulse carry the earlier payload.
- R8: A write or vsync pulse that lands while a packet is being sent leaves that packet unchanged. The new payload appears in the next packet.
- R9: enable is sampled only at the packet start slot. When it is 0 there, no packet is sent. Dropping it mid-packet does not cut the packet short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Encoder on/off, sampled at packet start |
| wr_en | input | 1 | Payload byte write strobe |
| wr_sel | input | 1 | 0: low byte (p1..p6), 1: high byte (p7..p14) |
| wr_data | input | 8 | Payload byte |
| vsync | input | 1 | One-cycle vertical sync pulse, copies staged payload to active |
| sys625 | input | 1 | 0: 525-line timing, 1: 625-line timing |
| field | input | 1 | Field identifier, 0 or 1 |
| line_num | input | LINE_W | Frame line number |
| pix_pos | input | PIX_W | Pixel position from line sync reference |
| id_valid | output | 1 | Override active |
| id_level | output | LVL_W | Level code to substitute |

## Verification
The bench builds the encoder with BIT_INT=3, FRAC_NUM=1, FRAC_DEN=2 and START_PIX=5. Bits then alternate between 3 and 4 clocks, and a whole 70-clock packet fits inside a 100-pixel line. The short line lets the bench cover every line and field pairing in both line systems, mid-packet writes and enable drops within a short run. The odd/even bit-length pattern makes an off-by-one in the fractional accumulator visible on every second bit. The default line numbers and level codes are kept.

// File: rtl/vid_id_pkg.sv
package vid_id_pkg;
    localparam int PAY_BITS = 14;
    localparam int CRC_BITS = 6;
    localparam int PKT_BITS = PAY_BITS + CRC_BITS;
    localparam int LO_BITS  = 6;
    localparam int IDX_W    = $clog2(PKT_BITS);

    typedef struct packed {
        logic [PAY_BITS-1:0] stage;
        logic [PAY_BITS-1:0] act;
    } pay_regs_t;
endpackage

// File: rtl/vid_id_regs.sv
module vid_id_regs
    import vid_id_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [7:0]          wr_data,
    input  logic                vsync,
    output logic [PAY_BITS-1:0] act_pay
);
    pay_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (vsync) begin
            r_d.act = r_q.stage;
        end
        if (wr_en) begin
            if (!wr_sel) begin
                r_d.stage[LO_BITS-1:0] = wr_data[LO_BITS-1:0];
            end else begin
                r_d.stage[PAY_BITS-1:LO_BITS] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign act_pay = r_q.act;
endmodule

// File: rtl/vid_id_crc.sv
module vid_id_crc
    import vid_id_pkg::*;
(
    input  logic [PAY_BITS-1:0] pay,
    output logic [CRC_BITS-1:0] crc
);
    always_comb begin
        logic [CRC_BITS-1:0] c;
        logic                fb;
        c = '1;
        for (int i = 0; i < PAY_BITS; i++) begin
            fb = c[CRC_BITS-1] ^ pay[i];
            c  = {c[CRC_BITS-2:0], 1'b0} ^ {{(CRC_BITS-2){1'b0}}, fb, fb};
        end
        crc = c;
    end
endmodule

// File: rtl/vid_id_ser.sv
module vid_id_ser
    import vid_id_pkg::*;
#(
    parameter int BIT_INT  = 60,
    parameter int FRAC_NUM = 7,
    parameter int FRAC_DEN = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PKT_BITS-1:0] pkt,
    output logic                valid,
    output logic                bit_out
);
    localparam int CNT_W = $clog2(BIT_INT + 1);
    localparam int ACC_W = $clog2(FRAC_DEN + FRAC_NUM + 1);
    localparam logic [ACC_W-1:0] NUM_V = ACC_W'(FRAC_NUM);
    localparam logic [ACC_W-1:0] DEN_V = ACC_W'(FRAC_DEN);
    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BIT_INT - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BITS - 1);

    typedef struct packed {
        logic                busy;
        logic [IDX_W-1:0]    idx;
        logic [CNT_W-1:0]    cnt;
        logic [ACC_W-1:0]    acc;
        logic [PKT_BITS-1:0] shreg;
    } ser_t;

    ser_t s_d, s_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] acc_nx;
    logic             extra;
    logic [CNT_W-1:0] len_m1;

    always_comb begin
        acc_sum = (s_q.busy ? s_q.acc : '0) + NUM_V;
        extra   = (acc_sum >= DEN_V);
        acc_nx  = extra ? (acc_sum - DEN_V) : acc_sum;
        len_m1  = BASE_M1 + CNT_W'(extra);

        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.idx   = '0;
                s_d.shreg = pkt;
                s_d.cnt   = len_m1;
                s_d.acc   = acc_nx;
            end
        end else if (s_q.cnt == '0) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.idx   = s_q.idx + 1'b1;
                s_d.shreg = {s_q.shreg[PKT_BITS-2:0], 1'b0};
                s_d.cnt   = len_m1;
                s_d.acc   = acc_nx;
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid   = s_q.busy;
    assign bit_out = s_q.shreg[PKT_BITS-1];
endmodule

// File: rtl/vid_id_enc.sv
module vid_id_enc
    import vid_id_pkg::*;
#(
    parameter int LINE_W      = 10,
    parameter int PIX_W       = 11,
    parameter int LVL_W       = 10,
    parameter int START_PIX   = 302,
    parameter int BIT_INT     = 60,
    parameter int FRAC_NUM    = 7,
    parameter int FRAC_DEN    = 20,
    parameter int LINE_F0     = 20,
    parameter int LINE_F1_525 = 283,
    parameter int LINE_F1_625 = 333,
    parameter int HI_CODE     = 640,
    parameter int LO_CODE     = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              vsync,
    input  logic              sys625,
    input  logic              field,
    input  logic [LINE_W-1:0] line_num,
    input  logic [PIX_W-1:0]  pix_pos,
    output logic              id_valid,
    output logic [LVL_W-1:0]  id_level
);
    localparam logic [LINE_W-1:0] L0_V   = LINE_W'(LINE_F0);
    localparam logic [LINE_W-1:0] L525_V = LINE_W'(LINE_F1_525);
    localparam logic [LINE_W-1:0] L625_V = LINE_W'(LINE_F1_625);
    localparam logic [PIX_W-1:0]  SP_V   = PIX_W'(START_PIX);
    localparam logic [LVL_W-1:0]  HI_V   = LVL_W'(HI_CODE);
    localparam logic [LVL_W-1:0]  LO_V   = LVL_W'(LO_CODE);

    logic [PAY_BITS-1:0] act_pay;
    logic [CRC_BITS-1:0] crc;
    logic [PKT_BITS-1:0] pkt;
    logic                line_hit;
    logic                start;
    logic                bit_out;

    vid_id_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .vsync   (vsync),
        .act_pay (act_pay)
    );

    vid_id_crc u_crc (
        .pay (act_pay),
        .crc (crc)
    );

    // p1 goes to the packet MSB so it leaves first
    always_comb begin
        for (int i = 0; i < PAY_BITS; i++) begin
            pkt[PKT_BITS-1-i] = act_pay[i];
        end
        pkt[CRC_BITS-1:0] = crc;
    end

    always_comb begin
        if (field) begin
            line_hit = (line_num == (sys625 ? L625_V : L525_V));
        end else begin
            line_hit = (line_num == L0_V);
        end
        start = enable && line_hit && (pix_pos == SP_V) && !id_valid;
    end

    vid_id_ser #(
        .BIT_INT  (BIT_INT),
        .FRAC_NUM (FRAC_NUM),
        .FRAC_DEN (FRAC_DEN)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .pkt     (pkt),
        .valid   (id_valid),
        .bit_out (bit_out)
    );

    assign id_level = (id_valid && bit_out) ? HI_V : LO_V;
endmodule

// File: rtl/vid_id_enc_chk.sv
module vid_id_enc_chk #(
    parameter int LINE_W      = 10,
    parameter int PIX_W       = 11,
    parameter int LVL_W       = 10,
    parameter int START_PIX   = 302,
    parameter int TOTAL       = 1207,
    parameter int LINE_F0     = 20,
    parameter int LINE_F1_525 = 283,
    parameter int LINE_F1_625 = 333,
    parameter int HI_CODE     = 640,
    parameter int LO_CODE     = 240,
    parameter int PAY_W       = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              vsync,
    input logic              sys625,
    input logic              field,
    input logic [LINE_W-1:0] line_num,
    input logic [PIX_W-1:0]  pix_pos,
    input logic              id_valid,
    input logic [LVL_W-1:0]  id_level,
    input logic [PAY_W-1:0]  act_pay
);
    localparam int RUN_W = $clog2(TOTAL + 1);
    logic [RUN_W-1:0] run_q;
    logic             hit;

    always_ff @(posedge clk) begin
        if (!rst_n || !id_valid) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = field ? (int'(line_num) == (sys625 ? LINE_F1_625 : LINE_F1_525))
                       : (int'(line_num) == LINE_F0);

    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> id_level == LVL_W'(LO_CODE));
    a_r6_level_codes: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (id_level == LVL_W'(HI_CODE) || id_level == LVL_W'(LO_CODE)));
    a_r5_start_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_valid) |-> $past(pix_pos) == PIX_W'(START_PIX));
    a_r4_line_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_valid) |-> $past(hit));
    a_r9_enable_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_valid) |-> $past(enable));
    a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> run_q < RUN_W'(TOTAL));
    a_r5_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_valid) |-> $past(run_q) == RUN_W'(TOTAL - 1));
    a_r7_vsync_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vsync) |-> $stable(act_pay));
endmodule

bind vid_id_enc vid_id_enc_chk #(
    .LINE_W      (LINE_W),
    .PIX_W       (PIX_W),
    .LVL_W       (LVL_W),
    .START_PIX   (START_PIX),
    .TOTAL       (20 * BIT_INT + (20 * FRAC_NUM) / FRAC_DEN),
    .LINE_F0     (LINE_F0),
    .LINE_F1_525 (LINE_F1_525),
    .LINE_F1_625 (LINE_F1_625),
    .HI_CODE     (HI_CODE),
    .LO_CODE     (LO_CODE),
    .PAY_W       (14)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .vsync    (vsync),
    .sys625   (sys625),
    .field    (field),
    .line_num (line_num),
    .pix_pos  (pix_pos),
    .id_valid (id_valid),
    .id_level (id_level),
    .act_pay  (act_pay)
);

// File: tb/vid_id_enc_tb.sv
module vid_id_enc_tb;
    localparam int BIT_INT = 3, FRAC_NUM = 1, FRAC_DEN = 2, START_PIX = 5;
    localparam int TOTAL = 20 * BIT_INT + (20 * FRAC_NUM) / FRAC_DEN;
    localparam int LINE_LEN = 100;
    localparam int HI = 640, LO = 240;

    logic clk = 0, rst_n = 0, enable = 0, wr_en = 0, wr_sel = 0, vsync = 0;
    logic sys625 = 0, field = 0;
    logic [7:0] wr_data = 0;
    logic [9:0] line_num = 0;
    logic [10:0] pix_pos = 0;
    logic id_valid;
    logic [9:0] id_level;

    vid_id_enc #(.START_PIX(START_PIX), .BIT_INT(BIT_INT),
                 .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vsync(vsync), .sys625(sys625), .field(field),
        .line_num(line_num), .pix_pos(pix_pos), .id_valid(id_valid), .id_level(id_level));

    always #10 clk = ~clk;

    typedef struct { logic [19:0] pkt; string tag; } exp_t;
    exp_t exp_q[$];
    int tests = 0, fails = 0, pushed = 0, seen = 0;
    bit done = 0;
    logic [13:0] stage_m = 0, act_m = 0;
    bit en_m = 0;
    int bidx[TOTAL];

    task automatic check(bit ok, string tag, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic logic [19:0] build_pkt(logic [13:0] p);
        logic [5:0] c = 6'h3F;
        logic fb;
        logic [19:0] r;
        for (int i = 0; i < 14; i++) begin
            fb = c[5] ^ p[i];
            c = {c[4:0], 1'b0} ^ {4'b0, fb, fb};
            r[19-i] = p[i];
        end
        r[5:0] = c;
        return r;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(bit sel, logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        if (!sel) stage_m[5:0] = d[5:0]; else stage_m[13:6] = d;
        step();
        wr_en = 0;
    endtask

    task automatic pulse_vsync();
        vsync = 1; act_m = stage_m;
        step();
        vsync = 0;
    endtask

    // mode 0: plain; 1: write+vsync mid-packet; 2: drop enable mid-packet
    task automatic send_line(int ln, bit fl, bit s625, int mode, string tag);
        bit hit;
        exp_t it;
        hit = fl ? (ln == (s625 ? 333 : 283)) : (ln == 20);
        if (hit && en_m) begin
            it.pkt = build_pkt(act_m); it.tag = tag;
            exp_q.push_back(it); pushed++;
        end
        line_num = 10'(ln); field = fl; sys625 = s625;
        for (int p = 0; p < LINE_LEN; p++) begin
            pix_pos = 11'(p);
            if (mode == 1 && p == 30) begin
                wr_en = 1; wr_sel = 0; wr_data = 8'h2A; stage_m[5:0] = 6'h2A;
            end else if (mode == 1 && p == 40) begin
                vsync = 1; act_m = stage_m;
            end else if (mode == 2 && p == 20) begin
                enable = 0; en_m = 0;
            end
            step();
            wr_en = 0; vsync = 0;
        end
        pix_pos = 0; line_num = 0;
        step();
        check(seen == pushed, {tag, " packet count"}, seen, pushed);
    endtask

    // monitor / scoreboard
    bit in_pkt = 0;
    int pos = 0, mism = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (id_valid && !in_pkt) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R4 R9 unexpected packet", 1, 0);
                    cur.pkt = '0; cur.tag = "R4 R9 unexpected";
                end else begin
                    cur = exp_q.pop_front();
                    check(int'(pix_pos) == START_PIX + 1, {cur.tag, " R5 start"},
                          int'(pix_pos), START_PIX + 1);
                end
                in_pkt = 1; pos = 0; mism = 0;
            end
            if (id_valid) begin
                if (pos < TOTAL) begin
                    if (int'(id_level) != (cur.pkt[19 - bidx[pos]] ? HI : LO)) mism++;
                end
                pos++;
            end else if (in_pkt) begin
                check(pos == TOTAL, {cur.tag, " R5 length"}, pos, TOTAL);
                check(mism == 0, {cur.tag, " R2 R3 R6 bit levels"}, mism, 0);
                in_pkt = 0;
            end
        end
    end

    initial begin
        int acc = 0, k = 0, len;
        for (int b = 0; b < 20; b++) begin
            acc += FRAC_NUM; len = BIT_INT;
            if (acc >= FRAC_DEN) begin acc -= FRAC_DEN; len++; end
            for (int j = 0; j < len; j++) begin bidx[k] = b; k++; end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) step();
        rst_n = 1;
        #5;
        check(id_valid == 0, "R1 reset valid", int'(id_valid), 0);
        check(int'(id_level) == LO, "R1 reset level", int'(id_level), LO);
        step();
        send_line(20, 0, 0, 0, "R9 disabled");
        enable = 1; en_m = 1;
        send_line(20, 0, 0, 0, "R1 zero payload");
        wr_reg(0, 8'hD5);
        wr_reg(1, 8'h3C);
        send_line(20, 0, 0, 0, "R7 before vsync");
        pulse_vsync();
        send_line(20, 0, 0, 0, "R2 R7 after vsync");
        send_line(283, 1, 0, 0, "R4 field1 525");
        send_line(333, 1, 0, 0, "R4 333 in 525");
        send_line(20, 1, 0, 0, "R4 line20 field1");
        send_line(21, 0, 0, 0, "R4 line21");
        send_line(333, 1, 1, 0, "R4 field1 625");
        send_line(283, 1, 1, 0, "R4 283 in 625");
        send_line(20, 0, 0, 1, "R8 mid update");
        send_line(20, 0, 0, 0, "R8 next packet");
        wr_reg(0, 8'hFF);
        wr_reg(1, 8'hFF);
        pulse_vsync();
        send_line(20, 0, 1, 0, "R3 all ones");
        wr_reg(0, 8'h15);
        wr_reg(1, 8'hA5);
        pulse_vsync();
        send_line(283, 1, 0, 0, "R3 pattern");
        send_line(20, 0, 0, 2, "R9 drop mid packet");
        send_line(20, 0, 0, 0, "R9 off after drop");
        #5;
        check(int'(id_level) == LO, "R6 idle level", int'(id_level), LO);
        check(exp_q.size() == 0, "R4 missed packets", exp_q.size(), 0);
        finish_run();
    end
endmodule